// File: doc/BRIEF.md
# DRAM Auto-Refresh Postponement Scheduler

This block decides when a DRAM controller should ask its command path for an auto-refresh. A free-running interval timer marks a refresh as due once every `intervalCnt + 1` clock cycles. Each due refresh is added to a pending count. Each accepted grant takes one off that count. The single output, `refReq`, asks the command path to issue one refresh.

With `postponeEn` low, the block runs in periodic mode. It requests as soon as anything is pending, whether the controller is busy or not. With `postponeEn` high, it lets due refreshes pile up while the controller reports busy, and requests them only when the controller goes idle. It also forces the request on once the backlog reaches an effective limit. That limit is the programmed `accumLimit`, with zero read as one, clamped to a ceiling set by the memory type: eight for DDR2/DDR3 and four for low-power DDR. If the enable is cleared while a backlog is held, the block keeps requesting until the backlog is drained, then falls back to one request per interval.

Top module: `ref_postpone_sched`

## Requirements
- R1: While the synchronous reset `rst` is high, the timer and the pending count are cleared. In the first cycle after reset `refReq` is 0, and the first due refresh comes `intervalCnt + 1` cycles after reset is released.
- R2: With `postponeEn` = 0, a due refresh raises `refReq` in the next cycle whatever the value of `ctlIdle`. `refReq` stays high while the pending count is nonzero.
- R3: With `postponeEn` = 1, `ctlIdle` = 0 and a pending count below the effective limit, `refReq` is 0.
- R4: With `postponeEn` = 1 and `ctlIdle` = 1, `refReq` is 1 whenever the pending count is nonzero.
- R5: With `postponeEn` = 1, `refReq` is forced to 1 while the pending count is at or above the effective limit, even when `ctlIdle` = 0.
- R6: The effective limit is `accumLimit`, with 0 treated as 1, clamped to 8 when `memType` = 0 (DDR2/DDR3) and to 4 when `memType` = 1 (low-power DDR).
- R7: A `refGrant` sampled while `refReq` = 1 lowers the pending count by one. A `refGrant` while `refReq` = 0 has no effect.
- R8: When a refresh falls due in the same cycle as an accepted grant, the pending count is unchanged.
- R9: Clearing `postponeEn` with a backlog pending keeps `refReq` high until that many grants have been accepted. After that, requests return to one per interval.
- R10: The pending count never exceeds the memory-type ceiling. A refresh falling due at the ceiling with no grant is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intervalCnt | input | INTV_W (16) | Refresh period minus one, in clock cycles |
| postponeEn | input | 1 | 1 = postponed mode, 0 = periodic mode |
| accumLimit | input | CNT_W (4) | Programmed backlog limit in postponed mode |
| memType | input | 1 | 0 = DDR2/DDR3 (ceiling 8), 1 = low-power DDR (ceiling 4) |
| ctlIdle | input | 1 | 1 = command path idle, 0 = busy |
| refGrant | input | 1 | Command path accepts one refresh |
| refReq | output | 1 | Refresh request |

## Verification
The bench targets the following corner cases, and each one catches a specific design error:
- **Limit clamping:** the edges of the effective limit are a programmed zero, a value above the ceiling, and each memory type. A design that clamps wrongly would force the request one backlog step too early or too late.
- **Due and grant together:** a due refresh and a grant in the same cycle should leave the count unchanged. A design that gets this wrong drifts by one, which shows as a request that ends a grant early or late.
- **Saturation at the ceiling:** a design that lets the count wrap past the ceiling would drop its request after a huge backlog.
- **Grants with no request:** a design that counts grants made while no request is up would lose pending refreshes.
- **Enable cleared with a backlog:** a design that stops requesting at once when the enable falls would strand the queued refreshes.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Strobes from control to datapath, one per pending-count action
  typedef struct packed {
    logic incPend;  // add one due refresh to the backlog
    logic decPend;  // retire one granted refresh
  } refStrb_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int INTV_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTV_W-1:0] intervalCnt,
  input  refStrb_t          strb,
  output logic              due,
  output logic [CNT_W-1:0]  pendCnt
);

  logic [INTV_W-1:0] timer;

  // Free-running interval timer, wraps after intervalCnt
  assign due = (timer >= intervalCnt);

  always_ff @(posedge clk) begin
    if (rst)      timer <= '0;
    else if (due) timer <= '0;
    else          timer <= timer + 1'b1;
  end

  // Backlog counter driven only by the control strobes
  always_ff @(posedge clk) begin
    if (rst)               pendCnt <= '0;
    else if (strb.incPend) pendCnt <= pendCnt + 1'b1;
    else if (strb.decPend) pendCnt <= pendCnt - 1'b1;
  end

endmodule

// File: rtl/refsched_ctl.sv
module refsched_ctl
  import refsched_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int CEIL_HI = 8,
  parameter int CEIL_LO = 4
) (
  input  logic             postponeEn,
  input  logic [CNT_W-1:0] accumLimit,
  input  logic             memType,
  input  logic             ctlIdle,
  input  logic             refGrant,
  input  logic             due,
  input  logic [CNT_W-1:0] pendCnt,
  output logic             refReq,
  output refStrb_t         strb
);

  localparam logic [CNT_W-1:0] CeilHiV = CNT_W'(CEIL_HI);
  localparam logic [CNT_W-1:0] CeilLoV = CNT_W'(CEIL_LO);
  localparam logic [CNT_W-1:0] OneV    = CNT_W'(1);

  logic [CNT_W-1:0] ceilSel;
  logic [CNT_W-1:0] limNz;
  logic [CNT_W-1:0] effLimit;
  logic             atCeil;
  logic             atLimit;
  logic             grantOk;

  // Limit resolution: zero reads as one, then clamp to the type ceiling
  always_comb begin
    ceilSel  = memType ? CeilLoV : CeilHiV;
    limNz    = (accumLimit == '0) ? OneV : accumLimit;
    effLimit = (limNz > ceilSel) ? ceilSel : limNz;
  end

  assign atCeil  = (pendCnt >= ceilSel);
  assign atLimit = (pendCnt >= effLimit);

  // Periodic mode asks at once; postponed mode waits for idle or limit
  assign refReq  = (pendCnt != '0) && (!postponeEn || ctlIdle || atLimit);
  assign grantOk = refGrant && refReq;

  always_comb begin
    strb.incPend = due && !atCeil && !grantOk;
    strb.decPend = grantOk && !due;
  end

endmodule

// File: rtl/ref_postpone_sched.sv
module ref_postpone_sched
  import refsched_pkg::*;
#(
  parameter int INTV_W  = 16,
  parameter int CEIL_HI = 8,
  parameter int CEIL_LO = 4,
  localparam int CNT_W  = $clog2(CEIL_HI + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTV_W-1:0] intervalCnt,
  input  logic              postponeEn,
  input  logic [CNT_W-1:0]  accumLimit,
  input  logic              memType,
  input  logic              ctlIdle,
  input  logic              refGrant,
  output logic              refReq
);

  refStrb_t         strb;
  logic             due;
  logic [CNT_W-1:0] pendCnt;

  refsched_ctl #(
    .CNT_W  (CNT_W),
    .CEIL_HI(CEIL_HI),
    .CEIL_LO(CEIL_LO)
  ) u_ctl (
    .postponeEn(postponeEn),
    .accumLimit(accumLimit),
    .memType   (memType),
    .ctlIdle   (ctlIdle),
    .refGrant  (refGrant),
    .due       (due),
    .pendCnt   (pendCnt),
    .refReq    (refReq),
    .strb      (strb)
  );

  refsched_dp #(
    .INTV_W(INTV_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .intervalCnt(intervalCnt),
    .strb       (strb),
    .due        (due),
    .pendCnt    (pendCnt)
  );

endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
  parameter int CNT_W   = 4,
  parameter int CEIL_HI = 8,
  parameter int CEIL_LO = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             postponeEn,
  input logic [CNT_W-1:0] accumLimit,
  input logic             memType,
  input logic             ctlIdle,
  input logic             refGrant,
  input logic             refReq,
  input logic             due,
  input logic [CNT_W-1:0] pendCnt
);

  // Independent limit computation from the ports
  logic [CNT_W-1:0] chkCeil;
  logic [CNT_W-1:0] chkLim;
  always_comb begin
    chkCeil = memType ? CNT_W'(CEIL_LO) : CNT_W'(CEIL_HI);
    chkLim  = (accumLimit == '0) ? CNT_W'(1) : accumLimit;
    if (chkLim > chkCeil) chkLim = chkCeil;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pendCnt == '0 && !refReq));

  a_r2_periodic_req: assert property (@(posedge clk) disable iff (rst)
    (!postponeEn && pendCnt != '0) |-> refReq);

  a_r3_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (postponeEn && !ctlIdle && pendCnt < chkLim) |-> !refReq);

  a_r4_idle_drain: assert property (@(posedge clk) disable iff (rst)
    (postponeEn && ctlIdle && pendCnt != '0) |-> refReq);

  a_r5_force_at_limit: assert property (@(posedge clk) disable iff (rst)
    (postponeEn && pendCnt != '0 && pendCnt >= chkLim) |-> refReq);

  a_r7_grant_dec: assert property (@(posedge clk) disable iff (rst)
    (!due && refGrant && refReq) |=> (pendCnt == $past(pendCnt) - 1'b1));

  a_r7_no_req_ignore: assert property (@(posedge clk) disable iff (rst)
    (!due && !refReq) |=> $stable(pendCnt));

  a_r8_due_grant_hold: assert property (@(posedge clk) disable iff (rst)
    (due && refGrant && refReq) |=> $stable(pendCnt));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    pendCnt <= CNT_W'(CEIL_HI));

endmodule

bind ref_postpone_sched refsched_chk #(
  .CNT_W  (CNT_W),
  .CEIL_HI(CEIL_HI),
  .CEIL_LO(CEIL_LO)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .postponeEn(postponeEn),
  .accumLimit(accumLimit),
  .memType   (memType),
  .ctlIdle   (ctlIdle),
  .refGrant  (refGrant),
  .refReq    (refReq),
  .due       (due),
  .pendCnt   (pendCnt)
);

// File: tb/test_ref_postpone_sched.sv
module test_ref_postpone_sched;

  localparam int INTV_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [INTV_W-1:0] intervalCnt = '0;
  logic              postponeEn = 1'b0;
  logic [CNT_W-1:0]  accumLimit = '0;
  logic              memType = 1'b0;
  logic              ctlIdle = 1'b0;
  logic              refGrant = 1'b0;
  logic              refReq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Next-cycle input values, applied inside step
  logic              nRst = 1'b1;
  logic [INTV_W-1:0] nIntv = '0;
  logic              nEn = 1'b0;
  logic [CNT_W-1:0]  nLim = '0;
  logic              nMem = 1'b0;
  logic              nIdle = 1'b0;

  // Reference model state
  int  mTimer = 0;
  int  mPend  = 0;
  bit  mKnown = 1'b0;

  always #5 clk = ~clk;

  ref_postpone_sched i_ref_postpone_sched (
    .clk        (clk),
    .rst        (rst),
    .intervalCnt(intervalCnt),
    .postponeEn (postponeEn),
    .accumLimit (accumLimit),
    .memType    (memType),
    .ctlIdle    (ctlIdle),
    .refGrant   (refGrant),
    .refReq     (refReq)
  );

  function automatic int fCeil(input logic mt);
    return mt ? 4 : 8;
  endfunction

  function automatic int fEff(input int lim, input logic mt);
    int l;
    l = (lim == 0) ? 1 : lim;
    return (l > fCeil(mt)) ? fCeil(mt) : l;
  endfunction

  function automatic logic fReq(input int pend, input logic en, input logic idle,
                                input int lim, input logic mt);
    if (pend == 0) return 1'b0;
    return !en || idle || (pend >= fEff(lim, mt));
  endfunction

  function automatic string fTag(input int pend, input logic en, input logic idle,
                                 input int lim, input logic mt);
    if (!en) return "R2";
    if (pend != 0 && pend >= fEff(lim, mt)) return "R5";
    if (idle) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s refReq actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // gMode: 0 no grant, 1 grant always, 2 random biased grant
  task automatic step(input string tag, input int gMode);
    logic expReq;
    logic g;
    bit   dueM;
    string t;
    @(negedge clk);
    rst = nRst; intervalCnt = nIntv; postponeEn = nEn;
    accumLimit = nLim; memType = nMem; ctlIdle = nIdle;
    expReq = fReq(mPend, nEn, nIdle, int'(nLim), nMem);
    case (gMode)
      0:       g = 1'b0;
      1:       g = 1'b1;
      default: g = expReq ? ($urandom_range(0, 9) < 6) : ($urandom_range(0, 9) < 2);
    endcase
    refGrant = g;
    #1;
    if (!nRst && mKnown) begin
      t = (tag == "") ? fTag(mPend, nEn, nIdle, int'(nLim), nMem) : tag;
      check(t, refReq, expReq);
    end
    // Model update for the coming rising edge
    if (nRst) begin
      mTimer = 0; mPend = 0; mKnown = 1'b1;
    end else begin
      dueM = (mTimer >= int'(nIntv));
      mTimer = dueM ? 0 : mTimer + 1;
      if (dueM && !(g && expReq)) begin
        if (mPend < fCeil(nMem)) mPend++;
      end else if (!dueM && g && expReq) begin
        mPend--;
      end
    end
  endtask

  task automatic doReset();
    nRst = 1'b1;
    step("", 0);
    step("", 0);
    nRst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));

    // R1: reset state and first due after intervalCnt+1 cycles
    nIntv = 16'd3; nEn = 1'b0; nIdle = 1'b0; nLim = 4'd0; nMem = 1'b0;
    doReset();
    for (int i = 0; i < 4; i++) step("R1", 0);
    step("R1", 0);   // request now visible after first due

    // R2 periodic request while busy; R7 one grant retires it
    step("R2", 0);
    step("R7", 1);
    step("R7", 0);
    step("R2", 0);

    // R7 grant with no request has no effect
    nIntv = 16'd40; doReset();
    for (int i = 0; i < 10; i++) step("R7", 1);

    // R6/R3/R5/R10: DDR ceiling 8 with limit 15, busy, dense dues
    nIntv = 16'd1; nEn = 1'b1; nLim = 4'd15; nMem = 1'b0; nIdle = 1'b0;
    doReset();
    for (int i = 0; i < 30; i++) step("R6", 0);
    nIntv = 16'd200;
    for (int i = 0; i < 12; i++) step("R10", 1);

    // R6 low-power ceiling 4 with limit 12
    nIntv = 16'd1; nLim = 4'd12; nMem = 1'b1; doReset();
    for (int i = 0; i < 14; i++) step("R6", 0);
    for (int i = 0; i < 6; i++) step("R5", 1);

    // R6 limit zero acts as one
    nIntv = 16'd2; nLim = 4'd0; nMem = 1'b0; doReset();
    for (int i = 0; i < 6; i++) step("R6", 0);

    // R9 clear enable with a backlog of three
    nIntv = 16'd2; nLim = 4'd5; nEn = 1'b1; doReset();
    for (int i = 0; i < 9; i++) step("R3", 0);
    nIntv = 16'd100; nEn = 1'b0;
    for (int i = 0; i < 3; i++) step("R9", 0);
    for (int i = 0; i < 5; i++) step("R9", 1);

    // R8 due and grant together, every cycle due
    nIntv = 16'd0; nEn = 1'b1; nLim = 4'd3; nIdle = 1'b1; doReset();
    step("R8", 0);
    for (int i = 0; i < 8; i++) step("R8", 1);
    step("R8", 0);

    // Random phase
    for (int blk = 0; blk < 20; blk++) begin
      nEn   = 1'($urandom_range(0, 3) != 0);
      nLim  = 4'($urandom_range(0, 15));
      nMem  = 1'($urandom_range(0, 1));
      nIntv = 16'($urandom_range(0, 7));
      for (int c = 0; c < 250; c++) begin
        nIdle = 1'($urandom_range(0, 2) == 0);
        nRst  = 1'($urandom_range(0, 199) == 0);
        step("", 2);
      end
      nRst = 1'b0;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule